// File: doc/BRIEF.md
# Host Bus Outstanding-Request Queue with Deferral Admission

This block keeps track of host bus transactions that have been issued in a pipelined fashion and are still open. Every accepted request enters a strict first-in, first-out queue together with its address, its kind (memory or I/O, read or write) and a tag that names the target interface. The oldest entry is shown at the head and leaves the queue when its response phase is reported as complete. Entries always retire in the order in which they were accepted.

Alongside the queue, the block decides whether a new request that asks for a deferred response may have one. It counts the deferred transactions that are still open, both across the whole block and for each target interface. A request is granted deferral only while fewer than two are open in total and none is open to its own target. Otherwise it is told to retry. A completion pulse that carries a target tag closes one open deferral. The queue records each entry's decision so that the head shows whether the oldest transaction was deferred.

Top module: `host_req_queue`

## Requirements
- R1: After a synchronous active-low reset, the queue is empty (`q_empty`=1, `q_full`=0, `q_count`=0) and `dfr_pending` is 0.
- R2: Entries retire strictly in accept order. The head fields always describe the oldest entry still in the queue, and each `rsp_done` while the queue is not empty removes exactly that entry.
- R3: The queue holds at most 12 entries. `q_full` is registered and rises in the cycle after the twelfth entry is accepted. While `q_full` is 1, a request is not accepted and leaves the queue contents and `q_count` unchanged.
- R4: When an accepted request and an `rsp_done` arrive in the same cycle, `q_count` does not change and the head moves on to the next entry.
- R5: Request kind encoding is 0 memory read, 1 memory write, 2 I/O read, 3 I/O write. For memory kinds (bit 1 of the kind is 0), the stored head address has its low 6 bits forced to zero, giving the 64-byte line. I/O addresses are stored in full.
- R6: An accepted request with `req_defer_ask`=1 gets `defer_grant`=1 in the same cycle when fewer than two deferrals are open and none is open to its target. `dfr_pending` then rises by one on the next clock edge.
- R7: An accepted request with `req_defer_ask`=1 that arrives while two deferrals are open gets `retry`=1 and `defer_grant`=0, and `dfr_pending` does not change.
- R8: An accepted request with `req_defer_ask`=1 whose target already has an open deferral gets `retry`=1 and `defer_grant`=0, even when fewer than two deferrals are open in total.
- R9: A `dfr_done` pulse closes the open deferral of target `dfr_tgt` and lowers `dfr_pending` by one. After that, that target can be granted again. A pulse for a target with no open deferral has no effect.
- R10: An `rsp_done` while the queue is empty has no effect.
- R11: `defer_grant` and `retry` are both 0 for a request that does not ask for deferral, and for a request that is not accepted because the queue is full.
- R12: `head_deferred` shows 1 when the head entry was granted deferral on acceptance, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A new request is presented this cycle |
| req_addr | input | 32 | Request address |
| req_kind | input | 2 | Request kind (0 mem rd, 1 mem wr, 2 io rd, 3 io wr) |
| req_tgt | input | 2 | Target interface tag |
| req_defer_ask | input | 1 | Request asks for a deferred response |
| rsp_done | input | 1 | Response phase of the head entry completes |
| dfr_done | input | 1 | One open deferral has completed |
| dfr_tgt | input | 2 | Target of the completed deferral |
| defer_grant | output | 1 | Deferral granted to the current request |
| retry | output | 1 | Current request must be retried instead |
| head_addr | output | 32 | Address of the oldest entry |
| head_kind | output | 2 | Kind of the oldest entry |
| head_tgt | output | 2 | Target tag of the oldest entry |
| head_deferred | output | 1 | Oldest entry was granted deferral |
| q_full | output | 1 | Registered full flag; requests stall while set |
| q_empty | output | 1 | Registered empty flag |
| q_count | output | 4 | Number of entries held |
| dfr_pending | output | 2 | Number of open deferrals |

## Verification
A read or write pointer that drifts shows up at the very next pop: the head fields then describe the wrong transaction, so the order test compares every head against its expected value after each retire. A count that drifts away from the pointers makes `q_full` rise one cycle early or late, which the bench catches on the thirteenth request or when it drains the queue. A per-target flag that is stuck open or stuck closed turns a grant into a retry, or a retry into a grant, on the first request to that target after the fault, and `dfr_pending` shows a wrong total on the next edge.

// File: rtl/hrq_pkg.sv
// Package: shared types of the host request queue.
// Assumes the request kind is carried as two bits on the ports.
package hrq_pkg;

    // Request kind; bit 1 set means I/O space, clear means memory space.
    typedef enum logic [1:0] {
        KIND_MEM_RD = 2'd0,
        KIND_MEM_WR = 2'd1,
        KIND_IO_RD  = 2'd2,
        KIND_IO_WR  = 2'd3
    } req_kind_e;

    // True when the kind addresses memory space (line-granular).
    function automatic logic kind_is_mem(input req_kind_e k);
        return (k == KIND_MEM_RD) || (k == KIND_MEM_WR);
    endfunction

endpackage

// File: rtl/hrq_fifo.sv
// Module: strict-order storage of outstanding requests.
// Holds DEPTH entries in a circular buffer. Push and pop come in already
// qualified by the caller: no push while full, no pop while empty.
// Full and empty are registered flags derived from the next occupancy.
// Memory addresses are cut down to line granularity on the way in.
module hrq_fifo
    import hrq_pkg::*;
#(
    parameter int DEPTH     = 12,
    parameter int ADDR_W    = 32,
    parameter int LINE_BITS = 6,
    parameter int TGT_W     = 2,
    localparam int PTR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [ADDR_W-1:0] in_addr,
    input  req_kind_e         in_kind,
    input  logic [TGT_W-1:0]  in_tgt,
    input  logic              in_deferred,
    output logic [ADDR_W-1:0] out_addr,
    output req_kind_e         out_kind,
    output logic [TGT_W-1:0]  out_tgt,
    output logic              out_deferred,
    output logic              full,
    output logic              empty,
    output logic [CNT_W-1:0]  count
);

    localparam logic [PTR_W-1:0] LAST_PTR  = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] DEPTH_CNT = CNT_W'(DEPTH);

    logic [ADDR_W-1:0] mem_addr [DEPTH];
    req_kind_e         mem_kind [DEPTH];
    logic [TGT_W-1:0]  mem_tgt  [DEPTH];
    logic [DEPTH-1:0]  mem_dfr;

    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count_nxt;
    logic [ADDR_W-1:0] addr_store;

    // Clear the low line bits for memory kinds before storing.
    always_comb begin
        addr_store = in_addr;
        if (kind_is_mem(in_kind)) begin
            addr_store[LINE_BITS-1:0] = '0;
        end
    end

    // Next occupancy from the qualified push and pop.
    always_comb begin
        count_nxt = count;
        if (push && !pop) begin
            count_nxt = count + 1'b1;
        end else if (pop && !push) begin
            count_nxt = count - 1'b1;
        end
    end

    // Write the pushed entry into the slot under the write pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_dfr <= '0;
        end else if (push) begin
            mem_addr[wr_ptr] <= addr_store;
            mem_kind[wr_ptr] <= in_kind;
            mem_tgt[wr_ptr]  <= in_tgt;
            mem_dfr[wr_ptr]  <= in_deferred;
        end
    end

    // Advance the pointers with wrap and register count and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            full   <= 1'b0;
            empty  <= 1'b1;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            end
            count <= count_nxt;
            full  <= (count_nxt == DEPTH_CNT);
            empty <= (count_nxt == '0);
        end
    end

    // Present the oldest entry.
    always_comb begin
        out_addr     = mem_addr[rd_ptr];
        out_kind     = mem_kind[rd_ptr];
        out_tgt      = mem_tgt[rd_ptr];
        out_deferred = mem_dfr[rd_ptr];
    end

endmodule

// File: rtl/hrq_defer_ctl.sv
// Module: admission control for deferred responses.
// Keeps one open flag per target and a total of open deferrals.
// Grants deferral only while the total is below MAX_DEFER and the target
// has none open; otherwise an asking request is told to retry.
// Assumes accept is already qualified by queue space.
module hrq_defer_ctl #(
    parameter int NUM_TGT   = 4,
    parameter int MAX_DEFER = 2,
    localparam int TGT_W    = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1,
    localparam int DCNT_W   = $clog2(MAX_DEFER + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              ask,
    input  logic [TGT_W-1:0]  tgt,
    input  logic              done,
    input  logic [TGT_W-1:0]  done_tgt,
    output logic              grant,
    output logic              retry,
    output logic [DCNT_W-1:0] pending
);

    localparam logic [DCNT_W-1:0] LIMIT = DCNT_W'(MAX_DEFER);

    logic [NUM_TGT-1:0] open_q;
    logic               done_ok;
    logic               room;

    // A completion counts only when its target really has one open.
    assign done_ok = done && open_q[done_tgt];
    assign room    = (pending < LIMIT) && !open_q[tgt];

    // Decide grant or retry for an accepted request that asks to defer.
    always_comb begin
        grant = accept && ask && room;
        retry = accept && ask && !room;
    end

    // One open flag per target interface.
    for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_q[t] <= 1'b0;
            end else if (grant && (tgt == TGT_W'(t))) begin
                open_q[t] <= 1'b1;
            end else if (done_ok && (done_tgt == TGT_W'(t))) begin
                open_q[t] <= 1'b0;
            end
        end
    end

    // Total of open deferrals, net of grant and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= '0;
        end else if (grant && !done_ok) begin
            pending <= pending + 1'b1;
        end else if (done_ok && !grant) begin
            pending <= pending - 1'b1;
        end
    end

endmodule

// File: rtl/host_req_queue.sv
// Module: top of the outstanding host request queue.
// Accepts a request whenever the registered full flag is clear, asks the
// admission control for a deferral decision and stores that decision with
// the entry. The head entry retires on rsp_done; rsp_done while empty is
// ignored. Assumes one request per cycle at most.
module host_req_queue
    import hrq_pkg::*;
#(
    parameter int DEPTH     = 12,
    parameter int ADDR_W    = 32,
    parameter int LINE_BITS = 6,
    parameter int NUM_TGT   = 4,
    parameter int MAX_DEFER = 2,
    localparam int TGT_W    = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1,
    localparam int CNT_W    = $clog2(DEPTH + 1),
    localparam int DCNT_W   = $clog2(MAX_DEFER + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_kind,
    input  logic [TGT_W-1:0]  req_tgt,
    input  logic              req_defer_ask,
    input  logic              rsp_done,
    input  logic              dfr_done,
    input  logic [TGT_W-1:0]  dfr_tgt,
    output logic              defer_grant,
    output logic              retry,
    output logic [ADDR_W-1:0] head_addr,
    output logic [1:0]        head_kind,
    output logic [TGT_W-1:0]  head_tgt,
    output logic              head_deferred,
    output logic              q_full,
    output logic              q_empty,
    output logic [CNT_W-1:0]  q_count,
    output logic [DCNT_W-1:0] dfr_pending
);

    logic      accept;
    logic      retire;
    req_kind_e head_kind_e;

    // Qualify push by space and pop by occupancy.
    assign accept = req_valid && !q_full;
    assign retire = rsp_done && !q_empty;

    hrq_defer_ctl #(
        .NUM_TGT  (NUM_TGT),
        .MAX_DEFER(MAX_DEFER)
    ) u_defer (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .ask     (req_defer_ask),
        .tgt     (req_tgt),
        .done    (dfr_done),
        .done_tgt(dfr_tgt),
        .grant   (defer_grant),
        .retry   (retry),
        .pending (dfr_pending)
    );

    hrq_fifo #(
        .DEPTH    (DEPTH),
        .ADDR_W   (ADDR_W),
        .LINE_BITS(LINE_BITS),
        .TGT_W    (TGT_W)
    ) u_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .push        (accept),
        .pop         (retire),
        .in_addr     (req_addr),
        .in_kind     (req_kind_e'(req_kind)),
        .in_tgt      (req_tgt),
        .in_deferred (defer_grant),
        .out_addr    (head_addr),
        .out_kind    (head_kind_e),
        .out_tgt     (head_tgt),
        .out_deferred(head_deferred),
        .full        (q_full),
        .empty       (q_empty),
        .count       (q_count)
    );

    assign head_kind = head_kind_e;

endmodule

// File: rtl/hrq_checker.sv
// Module: property checker for host_req_queue, attached by bind.
// Observes ports only; all properties are disabled during reset.
module hrq_checker #(
    parameter int DEPTH     = 12,
    parameter int MAX_DEFER = 2,
    localparam int CNT_W    = $clog2(DEPTH + 1),
    localparam int DCNT_W   = $clog2(MAX_DEFER + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_defer_ask,
    input logic              rsp_done,
    input logic              defer_grant,
    input logic              retry,
    input logic              q_full,
    input logic              q_empty,
    input logic [CNT_W-1:0]  q_count,
    input logic [DCNT_W-1:0] dfr_pending
);

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (q_full && !rsp_done) |=> (q_count == CNT_W'(DEPTH)));

    a_r4_push_pop_same: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !q_full && rsp_done && !q_empty) |=> $stable(q_count));

    a_r10_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (q_empty && rsp_done && !req_valid) |=> q_empty);

    a_r7_global_limit: assert property (@(posedge clk) disable iff (!rst_n)
        dfr_pending <= DCNT_W'(MAX_DEFER));

    a_r7_retry_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !q_full && req_defer_ask && dfr_pending == DCNT_W'(MAX_DEFER))
        |-> (retry && !defer_grant));

    a_r11_no_decision: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid || q_full || !req_defer_ask) |-> !(defer_grant || retry));

    a_r6_one_decision: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({defer_grant, retry}) <= 1);

endmodule

bind host_req_queue hrq_checker #(
    .DEPTH    (DEPTH),
    .MAX_DEFER(MAX_DEFER)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_defer_ask(req_defer_ask),
    .rsp_done     (rsp_done),
    .defer_grant  (defer_grant),
    .retry        (retry),
    .q_full       (q_full),
    .q_empty      (q_empty),
    .q_count      (q_count),
    .dfr_pending  (dfr_pending)
);

// File: tb/host_req_queue_tb.sv
// Directed bench for host_req_queue: one task per scenario.
module host_req_queue_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_kind = '0;
    logic [1:0]  req_tgt = '0;
    logic        req_defer_ask = 1'b0;
    logic        rsp_done = 1'b0;
    logic        dfr_done = 1'b0;
    logic [1:0]  dfr_tgt = '0;
    logic        defer_grant, retry, head_deferred, q_full, q_empty;
    logic [31:0] head_addr;
    logic [1:0]  head_kind, head_tgt, dfr_pending;
    logic [3:0]  q_count;

    int n_chk = 0;
    int n_bad = 0;
    logic got_grant, got_retry;

    always #5 clk = ~clk;

    host_req_queue u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_kind(req_kind), .req_tgt(req_tgt), .req_defer_ask(req_defer_ask),
        .rsp_done(rsp_done), .dfr_done(dfr_done), .dfr_tgt(dfr_tgt),
        .defer_grant(defer_grant), .retry(retry), .head_addr(head_addr),
        .head_kind(head_kind), .head_tgt(head_tgt), .head_deferred(head_deferred),
        .q_full(q_full), .q_empty(q_empty), .q_count(q_count),
        .dfr_pending(dfr_pending)
    );

    task automatic check(input logic ok, input string req,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req_valid = 0; rsp_done = 0; dfr_done = 0; req_defer_ask = 0;
        step(); step();
        rst_n = 1'b1;
    endtask

    // One request (optionally with rsp_done in the same cycle); decision captured.
    task automatic push(input logic [31:0] a, input logic [1:0] k,
                        input logic [1:0] t, input logic ask, input logic pop);
        req_valid = 1; req_addr = a; req_kind = k; req_tgt = t;
        req_defer_ask = ask; rsp_done = pop;
        #1;
        got_grant = defer_grant;
        got_retry = retry;
        step();
        req_valid = 0; req_defer_ask = 0; rsp_done = 0;
    endtask

    task automatic pop_one();
        rsp_done = 1; step(); rsp_done = 0;
    endtask

    task automatic complete(input logic [1:0] t);
        dfr_done = 1; dfr_tgt = t; step(); dfr_done = 0;
    endtask

    task automatic t_reset();
        do_reset();
        check(q_empty == 1, "R1 empty", q_empty, 1);
        check(q_full == 0, "R1 full", q_full, 0);
        check(q_count == 0, "R1 count", q_count, 0);
        check(dfr_pending == 0, "R1 pending", dfr_pending, 0);
    endtask

    task automatic t_order();
        do_reset();
        push(32'h0000_2040, 2'd2, 2'd1, 0, 0);
        push(32'h0000_3055, 2'd3, 2'd2, 0, 0);
        push(32'h0000_4066, 2'd2, 2'd3, 0, 0);
        check(head_addr == 32'h2040 && head_tgt == 1, "R2 head0", head_addr, 32'h2040);
        pop_one();
        check(head_addr == 32'h3055 && head_kind == 3, "R2 head1", head_addr, 32'h3055);
        pop_one();
        check(head_addr == 32'h4066 && head_tgt == 3, "R2 head2", head_addr, 32'h4066);
        pop_one();
        check(q_empty == 1, "R2 drained", q_empty, 1);
    endtask

    task automatic t_fill();
        do_reset();
        for (int i = 0; i < 12; i++) push(32'h100 + i, 2'd2, 2'd0, 0, 0);
        check(q_full == 1 && q_count == 12, "R3 full", q_count, 12);
        push(32'hDEAD, 2'd2, 2'd1, 1, 0);
        check(!got_grant && !got_retry, "R11 stalled no decision", {got_grant, got_retry}, 0);
        check(q_count == 12 && dfr_pending == 0, "R3 stall held", q_count, 12);
        for (int i = 0; i < 12; i++) begin
            check(head_addr == 32'h100 + i, "R3 drain order", head_addr, 32'h100 + i);
            pop_one();
        end
        check(q_empty == 1, "R3 no 13th entry", q_empty, 1);
    endtask

    task automatic t_push_pop();
        do_reset();
        push(32'h500, 2'd2, 0, 0, 0);
        push(32'h600, 2'd2, 0, 0, 0);
        push(32'h700, 2'd2, 0, 0, 1);
        check(q_count == 2, "R4 count stable", q_count, 2);
        check(head_addr == 32'h600, "R4 head moved", head_addr, 32'h600);
    endtask

    task automatic t_line();
        do_reset();
        push(32'h1234_567F, 2'd0, 0, 0, 0);
        push(32'h1234_56BF, 2'd1, 0, 0, 0);
        push(32'h0000_0CF3, 2'd2, 0, 0, 0);
        check(head_addr == 32'h1234_5640, "R5 mem rd line", head_addr, 32'h1234_5640);
        pop_one();
        check(head_addr == 32'h1234_5680, "R5 mem wr line", head_addr, 32'h1234_5680);
        pop_one();
        check(head_addr == 32'h0000_0CF3, "R5 io full addr", head_addr, 32'hCF3);
    endtask

    task automatic t_defer();
        do_reset();
        push(32'h10, 2'd2, 2'd0, 1, 0);
        check(got_grant && !got_retry, "R6 first grant", {got_grant, got_retry}, 2);
        check(dfr_pending == 1, "R6 pending up", dfr_pending, 1);
        push(32'h20, 2'd2, 2'd0, 1, 0);
        check(!got_grant && got_retry, "R8 same target retry", {got_grant, got_retry}, 1);
        check(dfr_pending == 1, "R8 pending held", dfr_pending, 1);
        push(32'h30, 2'd3, 2'd1, 1, 0);
        check(got_grant, "R6 second target grant", got_grant, 1);
        push(32'h40, 2'd2, 2'd2, 1, 0);
        check(!got_grant && got_retry, "R7 global retry", {got_grant, got_retry}, 1);
        check(dfr_pending == 2, "R7 pending capped", dfr_pending, 2);
        push(32'h50, 2'd2, 2'd3, 0, 0);
        check(!got_grant && !got_retry, "R11 no ask", {got_grant, got_retry}, 0);
        check(head_deferred == 1, "R12 head deferred", head_deferred, 1);
        pop_one();
        check(head_deferred == 0, "R12 head retried", head_deferred, 0);
        complete(2'd3);
        check(dfr_pending == 2, "R9 stray completion", dfr_pending, 2);
        complete(2'd0);
        check(dfr_pending == 1, "R9 completion", dfr_pending, 1);
        push(32'h60, 2'd2, 2'd0, 1, 0);
        check(got_grant, "R9 regrant target", got_grant, 1);
        check(dfr_pending == 2, "R9 pending again", dfr_pending, 2);
    endtask

    task automatic t_empty_pop();
        do_reset();
        pop_one();
        check(q_empty == 1 && q_count == 0, "R10 empty pop", q_count, 0);
        push(32'h900, 2'd2, 0, 0, 0);
        check(q_count == 1 && head_addr == 32'h900, "R10 push after", q_count, 1);
    endtask

    initial begin : watchdog
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_order();
        t_fill();
        t_push_pop();
        t_line();
        t_defer();
        t_empty_pop();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule